// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is the master side of a byte-wide slave parallel configuration port. A one-cycle start pulse together with a byte count launches a load. The block pulses the target's active-low program line and waits for the target to clear its memory and signal that it is ready. It then asserts chip select and write, waits a settling interval, and clocks the bitstream out one byte at a time from a valid/ready byte stream. Each byte goes onto the bus, and the configuration clock drops and rises so that the target captures the byte on the rising edge.

The three target status pins are synchronised on entry and watched throughout the load. The init pin falling during data indicates a checksum error. A busy pin that stays high stalls the load. The done pin may rise before every byte has been sent. Every wait is guarded by a timeout whose length is a cycle-count parameter. A load ends with a one-cycle success or failure pulse. A 3-bit error code and the offset of the failing byte remain readable until the next start.

Top module: `pcfg_loader`

## Requirements
- R1: After reset, and whenever no load is running, the program, chip-select and write strobes are high, the configuration clock is high, the bus drive enable is low, stream ready is low, and the ok and fail pulses are low.
- R2: A start holds the program strobe low for at least PROG_MIN_CYC cycles, and releases it only once the init pin has been seen low. If init has not gone low within INIT_TMO_CYC cycles, the load fails with error code 1.
- R3: After the program strobe is released, no data strobe is asserted until init is high and busy is low. If that condition is not met within INIT_TMO_CYC cycles, the load fails with error code 2.
- R4: Chip select and write go low at least SETTLE_CYC cycles before the first byte is requested from the stream.
- R5: Each byte is driven on the bus, with drive enabled, before the configuration clock falls. The clock then rises to capture it. The target receives the bytes in stream order.
- R6: A byte is taken from the stream only in a cycle where ready and valid are both high. At most the programmed count of bytes is taken, and a count of zero sends no byte.
- R7: If the done pin is high before a byte is sent, loading stops and the block goes to the final check. This counts as success when the check passes.
- R8: If init is low before a byte is sent, the load fails with error code 3. The error offset equals the number of bytes already sent.
- R9: With CHECK_BUSY set, the block waits after each byte until busy is low. If busy stays high for BUSY_TMO_CYC cycles, the load fails with error code 4.
- R10: After the last byte, chip select and write are released. The ok pulse follows only once done and init are both high. If they are not both high within DONE_TMO_CYC cycles, the load fails with error code 5, and the error code reads 0 on success.
- R11: A failure releases every strobe and disables the bus drive. It raises fail for exactly one cycle, and the nonzero error code (1 to 5) holds until the next start.
- R12: A start pulse that arrives while a load is running is ignored, and the running load completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a load |
| len_i | input | LEN_W | Number of bytes to send, sampled with start |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| prog_n_o | output | 1 | Active-low program strobe to target |
| cs_n_o | output | 1 | Active-low chip select to target |
| wr_n_o | output | 1 | Active-low write strobe to target |
| cclk_o | output | 1 | Configuration clock to target |
| d_o | output | 8 | Configuration data bus |
| d_oe_o | output | 1 | Bus drive enable (low means tri-stated) |
| init_n_i | input | 1 | Target init pin (low: clearing or error) |
| busy_i | input | 1 | Target busy pin |
| done_i | input | 1 | Target done pin |
| ok_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| err_code_o | output | 3 | Error code of the last failure, 0 if none |
| err_offset_o | output | LEN_W | Bytes sent when the last failure was detected |

## Verification
The critical overlap is the done pin rising, or init falling, in the same window as the block's readiness to send the next byte. The target model in the bench raises done or pulls init low on the very rising clock edge that captures a chosen byte, and also pulses busy on that same capture. This makes the post-byte busy wait, the status check and the next stream request collide. The outcome is judged by how many bytes the model captured, by the result pulse, and by the recorded offset. A start pulse injected in the middle of a load likewise overlaps a running transfer, and it must leave the captured count unchanged.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAKE,
        ST_SETTLE,
        ST_LOAD,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_BUSY,
        ST_FINISH
    } ld_state_t;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_NO_CLEAR = 3'd1,
        ERR_NO_WAKE  = 3'd2,
        ERR_CRC      = 3'd3,
        ERR_BUSY_TMO = 3'd4,
        ERR_DONE_TMO = 3'd5
    } ld_err_t;

    typedef struct packed {
        logic init_n;
        logic busy;
        logic done;
    } tgt_pins_t;

    localparam tgt_pins_t PINS_IDLE = '{init_n: 1'b1, busy: 1'b0, done: 1'b0};

    typedef struct packed {
        logic prog_n;
        logic cs_n;
        logic wr_n;
        logic cclk;
        logic d_oe;
    } strobes_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobes_t strobes_for(input ld_state_t s);
        strobes_t r;
        r = '{prog_n: 1'b1, cs_n: 1'b1, wr_n: 1'b1, cclk: 1'b1, d_oe: 1'b0};
        case (s)
            ST_PROG: r.prog_n = 1'b0;
            ST_SETTLE, ST_LOAD, ST_CLK_HI, ST_BUSY: begin
                r.cs_n = 1'b0;
                r.wr_n = 1'b0;
                r.d_oe = 1'b1;
            end
            ST_CLK_LO: begin
                r.cs_n = 1'b0;
                r.wr_n = 1'b0;
                r.d_oe = 1'b1;
                r.cclk = 1'b0;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pcfg_pin_sync.sv
module pcfg_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] stg;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)      cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pcfg_byte_ctr.sv
module pcfg_byte_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         at_end
);
    assign at_end = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt <= '0;
        else if (inc && !at_end) cnt <= cnt + 1'b1;
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (!clr && $past(!clr) && $past(!rst)) |-> cnt <= limit) else $error("byte count beyond limit"); // R6
endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
    import pcfg_pkg::*;
#(
    parameter int          LEN_W        = 16,
    parameter int          SYNC_STAGES  = 2,
    parameter int unsigned PROG_MIN_CYC = 30,
    parameter int unsigned INIT_TMO_CYC = 50_000_000,
    parameter int unsigned SETTLE_CYC   = 1_000_000,
    parameter int unsigned BUSY_TMO_CYC = 500_000,
    parameter int unsigned DONE_TMO_CYC = 20_000_000,
    parameter bit          CHECK_BUSY   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             s_valid_i,
    input  logic [7:0]       s_data_i,
    output logic             s_ready_o,
    output logic             prog_n_o,
    output logic             cs_n_o,
    output logic             wr_n_o,
    output logic             cclk_o,
    output logic [7:0]       d_o,
    output logic             d_oe_o,
    input  logic             init_n_i,
    input  logic             busy_i,
    input  logic             done_i,
    output logic             ok_o,
    output logic             fail_o,
    output logic [2:0]       err_code_o,
    output logic [LEN_W-1:0] err_offset_o
);
    localparam int unsigned TMO_MAX = max_u(max_u(INIT_TMO_CYC, DONE_TMO_CYC),
                                            max_u(max_u(SETTLE_CYC, BUSY_TMO_CYC), PROG_MIN_CYC));
    localparam int          TW = $clog2(TMO_MAX + 2) + 1;
    localparam logic [TW-1:0] T_PROG   = TW'(PROG_MIN_CYC - 1);
    localparam logic [TW-1:0] T_INIT   = TW'(INIT_TMO_CYC - 1);
    localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] T_BUSY   = TW'(BUSY_TMO_CYC - 1);
    localparam logic [TW-1:0] T_DONE   = TW'(DONE_TMO_CYC - 1);
    localparam logic [TW-1:0] T_BMIN   = TW'(SYNC_STAGES + 1);

    ld_state_t        st_q, st_d;
    tgt_pins_t        pin_raw, pin;
    strobes_t         strb;
    logic [TW-1:0]    tmr;
    logic [LEN_W-1:0] len_q, sent;
    logic             at_end, accept, seen_q;
    logic             ok_now, fail_now;
    ld_err_t          code_now;
    logic [2:0]       err_q;
    logic [LEN_W-1:0] off_q;
    logic [7:0]       d_q;
    logic             ok_q, fail_q;
    logic             after_clk_hi;

    assign pin_raw = '{init_n: init_n_i, busy: busy_i, done: done_i};

    pcfg_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(pin_raw), .q(pin)
    );

    pcfg_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .clr(st_d != st_q), .cnt(tmr)
    );

    pcfg_byte_ctr #(.W(LEN_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(st_q == ST_IDLE && start_i), .inc(accept),
        .limit(len_q), .cnt(sent), .at_end(at_end)
    );

    // Stream is offered a slot only when a byte may legally go out now.
    assign s_ready_o = (st_q == ST_LOAD) && !at_end && !pin.done && pin.init_n;
    assign accept    = s_ready_o && s_valid_i;

    // With busy checking, every byte passes through the busy wait.
    if (CHECK_BUSY) begin : g_busy_on
        assign after_clk_hi = 1'b1;
    end else begin : g_busy_off
        assign after_clk_hi = 1'b0;
    end

    always_comb begin
        st_d     = st_q;
        ok_now   = 1'b0;
        fail_now = 1'b0;
        code_now = ERR_NONE;
        case (st_q)
            ST_IDLE: if (start_i) st_d = ST_PROG;
            ST_PROG: begin
                if (tmr >= T_PROG && (seen_q || !pin.init_n)) st_d = ST_WAKE;
                else if (tmr >= T_INIT) begin
                    fail_now = 1'b1;
                    code_now = ERR_NO_CLEAR;
                end
            end
            ST_WAKE: begin
                if (pin.init_n && !pin.busy) st_d = ST_SETTLE;
                else if (tmr >= T_INIT) begin
                    fail_now = 1'b1;
                    code_now = ERR_NO_WAKE;
                end
            end
            ST_SETTLE: if (tmr >= T_SETTLE) st_d = ST_LOAD;
            ST_LOAD: begin
                if (at_end || pin.done) st_d = ST_FINISH;
                else if (!pin.init_n) begin
                    fail_now = 1'b1;
                    code_now = ERR_CRC;
                end else if (accept) st_d = ST_CLK_LO;
            end
            ST_CLK_LO: st_d = ST_CLK_HI;
            ST_CLK_HI: st_d = after_clk_hi ? ST_BUSY : ST_LOAD;
            ST_BUSY: begin
                if (tmr >= T_BMIN && !pin.busy) st_d = ST_LOAD;
                else if (tmr >= T_BUSY) begin
                    fail_now = 1'b1;
                    code_now = ERR_BUSY_TMO;
                end
            end
            ST_FINISH: begin
                if (pin.done && pin.init_n) begin
                    ok_now = 1'b1;
                    st_d   = ST_IDLE;
                end else if (tmr >= T_DONE) begin
                    fail_now = 1'b1;
                    code_now = ERR_DONE_TMO;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (fail_now) st_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            seen_q <= 1'b0;
            len_q  <= '0;
            err_q  <= ERR_NONE;
            off_q  <= '0;
            d_q    <= '0;
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ok_q   <= ok_now;
            fail_q <= fail_now;
            if (st_q == ST_IDLE) begin
                seen_q <= 1'b0;
                if (start_i) begin
                    len_q <= len_i;
                    err_q <= ERR_NONE;
                    off_q <= '0;
                end
            end else if (st_q == ST_PROG && !pin.init_n) begin
                seen_q <= 1'b1;
            end
            if (accept) d_q <= s_data_i;
            if (fail_now) begin
                err_q <= code_now;
                off_q <= sent;
            end
        end
    end

    assign strb         = strobes_for(st_q);
    assign prog_n_o     = strb.prog_n;
    assign cs_n_o       = strb.cs_n;
    assign wr_n_o       = strb.wr_n;
    assign cclk_o       = strb.cclk;
    assign d_oe_o       = strb.d_oe;
    assign d_o          = d_q;
    assign ok_o         = ok_q;
    assign fail_o       = fail_q;
    assign err_code_o   = err_q;
    assign err_offset_o = off_q;

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ok_o && fail_o)) else $error("ok and fail together"); // R11
    AST_FAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> !fail_o) else $error("fail wider than one cycle"); // R11
    AST_FAIL_RELEASES: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> (prog_n_o && cs_n_o && wr_n_o && !d_oe_o)) else $error("strobe held after abort"); // R11
    AST_FAIL_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> err_code_o != 3'd0) else $error("fail with empty code"); // R11
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        ok_o |-> (err_code_o == 3'd0 && cs_n_o && wr_n_o)) else $error("ok with code or strobes"); // R10
    AST_DATA_BEFORE_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(cclk_o) |-> (d_oe_o && !cs_n_o && !wr_n_o)) else $error("clock fell without data"); // R5
    AST_READY_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        s_ready_o |-> (!cs_n_o && !wr_n_o && cclk_o)) else $error("ready outside write phase"); // R6
    AST_PROG_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        !prog_n_o |-> (cs_n_o && !d_oe_o)) else $error("data strobe during program"); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |=> len_q == $past(len_q)) else $error("length changed mid-load"); // R12
endmodule

// File: tb/pcfg_loader_test.sv
module pcfg_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 16;
    localparam int P_PROG = 4, P_INIT = 40, P_SETTLE = 8, P_BUSY = 20, P_DONE = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [LW-1:0] len_i = '0;
    logic s_valid_i = 1'b0;
    logic [7:0] s_data_i = '0;
    logic s_ready_o, prog_n_o, cs_n_o, wr_n_o, cclk_o, d_oe_o, ok_o, fail_o;
    logic [7:0] d_o;
    logic [2:0] err_code_o;
    logic [LW-1:0] err_offset_o;
    logic init_n_i = 1'b1, busy_i = 1'b0, done_i = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcfg_loader #(.LEN_W(LW), .SYNC_STAGES(2), .PROG_MIN_CYC(P_PROG), .INIT_TMO_CYC(P_INIT),
                  .SETTLE_CYC(P_SETTLE), .BUSY_TMO_CYC(P_BUSY), .DONE_TMO_CYC(P_DONE),
                  .CHECK_BUSY(1'b1)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i), .s_valid_i(s_valid_i),
        .s_data_i(s_data_i), .s_ready_o(s_ready_o), .prog_n_o(prog_n_o), .cs_n_o(cs_n_o),
        .wr_n_o(wr_n_o), .cclk_o(cclk_o), .d_o(d_o), .d_oe_o(d_oe_o), .init_n_i(init_n_i),
        .busy_i(busy_i), .done_i(done_i), .ok_o(ok_o), .fail_o(fail_o),
        .err_code_o(err_code_o), .err_offset_o(err_offset_o)
    );

    // Target model settings, written only by the stimulus process.
    localparam int M_NORMAL = 0, M_NO_LOW = 1, M_STAY_LOW = 2, M_CRC = 3,
                   M_EARLY = 4, M_BUSY_STUCK = 5, M_NO_DONE = 6;
    int mode = M_NORMAL;
    int m_done_at = 0;
    int m_crc_at = 0;

    // Target model state.
    logic [7:0] cap_mem [0:63];
    int  cap_cnt = 0;
    int  rel_cnt = 0;
    int  bpend = 0;
    logic prev_cclk = 1'b1;
    logic cfg_err = 1'b0;

    always @(negedge clk) begin
        prev_cclk <= cclk_o;
        if (!prog_n_o) begin
            init_n_i <= (mode == M_NO_LOW);
            done_i   <= 1'b0;
            busy_i   <= 1'b0;
            cap_cnt  <= 0;
            rel_cnt  <= 0;
            bpend    <= 0;
            cfg_err  <= 1'b0;
        end else begin
            if (!init_n_i && !cfg_err && mode != M_STAY_LOW) begin
                rel_cnt <= rel_cnt + 1;
                if (rel_cnt == 4) init_n_i <= 1'b1;
            end
            if (cclk_o && !prev_cclk && !cs_n_o && !wr_n_o) begin
                cap_mem[cap_cnt[5:0]] <= d_o;
                cap_cnt <= cap_cnt + 1;
                bpend   <= 2;
                busy_i  <= 1'b1;
                if (cap_cnt + 1 == m_crc_at) begin
                    init_n_i <= 1'b0;
                    cfg_err  <= 1'b1;
                end
                if (cap_cnt + 1 == m_done_at) done_i <= 1'b1;
            end else begin
                if (bpend > 0) bpend <= bpend - 1;
                busy_i <= (mode == M_BUSY_STUCK && cap_cnt > 0) || (bpend > 1);
            end
        end
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_code(input int md, input int len);
        case (md)
            M_NO_LOW:     return 1;
            M_STAY_LOW:   return 2;
            M_CRC:        return 3;
            M_BUSY_STUCK: return 4;
            M_NO_DONE:    return 5;
            default:      return (len == 0) ? 5 : 0;
        endcase
    endfunction

    function automatic int exp_bytes(input int md, input int len, input int k);
        case (md)
            M_NO_LOW, M_STAY_LOW: return 0;
            M_CRC, M_EARLY:       return k;
            M_BUSY_STUCK:         return 1;
            default:              return len;
        endcase
    endfunction

    logic [7:0] sbuf [0:63];

    task automatic run_case(input int md, input int len, input int k, input bit mid_start);
        int idx = 0;
        int prog_low = 0;
        int cyc = 0;
        int cs_fall = -1;
        int rdy_first = -1;
        int ok_cnt = 0;
        int fail_cnt = 0;
        int res_at = -1;
        int cclk_bad = 0;
        int accepted = 0;
        bit cs_seen = 1'b0;
        bit rel_ok = 1'b1;
        logic last_cclk = 1'b1;
        int ecode;
        int ebytes;
        bit match = 1'b1;
        mode = md;
        m_done_at = (md == M_EARLY) ? k : ((md == M_NO_DONE) ? 0 : len);
        m_crc_at  = (md == M_CRC) ? k : 0;
        for (int i = 0; i < 64; i++) sbuf[i] = 8'($urandom);
        @(negedge clk);
        len_i = LW'(len);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (cyc < 3000 && (res_at < 0 || cyc < res_at + 10)) begin
            if (!prog_n_o) prog_low++;
            if (!cs_n_o) begin
                cs_seen = 1'b1;
                if (cs_fall < 0) cs_fall = cyc;
            end
            if (s_ready_o && rdy_first < 0) rdy_first = cyc;
            if (last_cclk && !cclk_o && !d_oe_o) cclk_bad++;
            last_cclk = cclk_o;
            if (ok_o) ok_cnt++;
            if (fail_o) fail_cnt++;
            if ((ok_o || fail_o) && res_at < 0) begin
                res_at = cyc;
                rel_ok = prog_n_o && cs_n_o && wr_n_o && !d_oe_o && cclk_o;
            end
            if (mid_start && cyc == 40) begin
                start_i = 1'b1;
                len_i = LW'(len + 3);
            end else begin
                start_i = 1'b0;
            end
            if (idx < len) begin
                s_valid_i = ($urandom % 4) != 0;
                s_data_i  = sbuf[idx];
            end else begin
                s_valid_i = 1'b0;
            end
            if (s_valid_i && s_ready_o) begin
                idx++;
                accepted++;
            end
            cyc++;
            @(negedge clk);
        end
        s_valid_i = 1'b0;
        ecode  = exp_code(md, len);
        ebytes = exp_bytes(md, len, k);
        for (int i = 0; i < ebytes && i < 64; i++)
            if (cap_mem[i] != sbuf[i]) match = 1'b0;
        chk(ok_cnt == ((ecode == 0) ? 1 : 0), "R10", "ok pulses", ok_cnt, (ecode == 0) ? 1 : 0);
        chk(fail_cnt == ((ecode != 0) ? 1 : 0), "R11", "fail pulses", fail_cnt, (ecode != 0) ? 1 : 0);
        chk(int'(err_code_o) == ecode, "R11", "held error code", int'(err_code_o), ecode);
        chk(cap_cnt == ebytes, "R6", "bytes captured by target", cap_cnt, ebytes);
        chk(accepted == ebytes, "R6", "bytes taken from stream", accepted, ebytes);
        chk(match, "R5", "captured data in stream order", match, 1);
        chk(cclk_bad == 0, "R5", "clock falls without bus drive", cclk_bad, 0);
        chk(rel_ok, "R11", "strobes released at result", rel_ok, 1);
        if (md != M_NO_LOW)
            chk(prog_low >= P_PROG, "R2", "program low cycles", prog_low, P_PROG);
        if (md == M_STAY_LOW || md == M_NO_LOW)
            chk(!cs_seen, "R3", "chip select asserted before wake", cs_seen, 0);
        if (ebytes > 0)
            chk(rdy_first - cs_fall >= P_SETTLE, "R4", "settle before first request",
                rdy_first - cs_fall, P_SETTLE);
        if (md == M_CRC)
            chk(int'(err_offset_o) == k, "R8", "error offset", int'(err_offset_o), k);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(prog_n_o && cs_n_o && wr_n_o && cclk_o && !d_oe_o, "R1", "strobes in reset",
            {prog_n_o, cs_n_o, wr_n_o, cclk_o, d_oe_o}, 5'b11110);
        rst = 1'b0;
        @(negedge clk);
        chk(!s_ready_o && !ok_o && !fail_o && err_code_o == 3'd0, "R1", "idle outputs",
            {s_ready_o, ok_o, fail_o, err_code_o}, 0);
        for (int n = 0; n < 6; n++) run_case(M_NORMAL, 1 + int'($urandom % 24), 0, 1'b0);
        run_case(M_NORMAL, 1, 0, 1'b0);
        run_case(M_NO_LOW, 6, 0, 1'b0);     // R2 timeout
        run_case(M_STAY_LOW, 6, 0, 1'b0);   // R3 timeout
        run_case(M_CRC, 10, 3, 1'b0);       // R8
        run_case(M_CRC, 10, 1, 1'b0);       // R8 first byte
        run_case(M_EARLY, 12, 5, 1'b0);     // R7
        run_case(M_BUSY_STUCK, 8, 0, 1'b0); // R9
        run_case(M_NO_DONE, 7, 0, 1'b0);    // R10 timeout
        run_case(M_NORMAL, 0, 0, 1'b0);     // R6 zero length
        run_case(M_NORMAL, 14, 0, 1'b1);    // R12 start during load
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule